// File: doc/BRIEF.md
# Fault Campaign Sequencer

The block runs fault-injection campaigns on the debugger side without any host in the loop. A campaign is a list of command words in a local script array. The sequencer steps through the list and can program a watchpoint or breakpoint on the target's debug logic. It can also pause for a fixed number of cycles or block until a trigger arrives. A trigger is either an external pin or a watchpoint hit reported by the target. After the trigger it performs the memory fault operation through a word-level request/acknowledge port to the debug logic.

Two fault styles are supported. In the first, the faulty value is known ahead of time and is written straight to the target address. In the second, the sequencer reads the target word, flips the bits selected by a stored mask, and writes the result back to the same address. For a register target, the script sets a breakpoint instead of a watchpoint and ends with a resume command.

Every message the target's debug logic sends back is logged in order into a separate trace array. The trace array has its own read port for later flow analysis.

Top module: `fault_campaign_seq`

## Requirements
- R1: After reset, `done_o`, `dbg_req_o`, `trace_ovf_o` are 0 and `trace_count_o` is 0; the sequencer stays idle until a `start_i` pulse, after which it executes from script location 0.
- R2: Command word layout: opcode in bits [67:64], address in [63:32], operand in [31:0]; opcodes NOP=0, SETWP=1, SETBP=2, DELAY=3, WAITEV=4, WRITE=5, RMW=6, RESUME=7, END=8, any other code acts as NOP. SETWP issues a request of kind 1 and SETBP one of kind 2 carrying the command address; a request holds kind, address and data stable until acknowledged, the cycle after the acknowledge execution resumes.
- R3: DELAY with operand N inserts exactly N idle cycles: the next request rises N+3 cycles after the acknowledge that preceded the DELAY, when a request-issuing command follows it.
- R4: WAITEV blocks with no request until `wp_hit_i` or `ext_trig_i` is seen high for one cycle; the request of the following command rises two cycles after that cycle.
- R5: WRITE issues a request of kind 4 with the command address and the operand as data.
- R6: RMW issues a read (kind 3) of the command address; in the cycle after the read acknowledge a write (kind 4) to the same address follows, carrying the returned word XOR the operand mask, so each mask bit set flips exactly that bit.
- R7: RESUME issues a request of kind 5.
- R8: END, or completing the command in the last script location, raises `done_o`; no further request is issued while done.
- R9: Every cycle with `msg_valid_i` high stores `msg_data_i` at the next trace location in arrival order, and `trace_count_o` counts stored messages; this holds in any cycle, including the cycle of a read acknowledge.
- R10: Once the trace array holds its capacity of messages, later messages are dropped, the stored ones are unchanged, and `trace_ovf_o` is set and stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Pulse to run the campaign from location 0 |
| script_we_i | input | 1 | Script array write enable |
| script_waddr_i | input | 4 | Script array write location |
| script_wdata_i | input | 68 | Command word to store |
| wp_hit_i | input | 1 | Watchpoint/breakpoint hit from the target debug logic |
| ext_trig_i | input | 1 | External trigger |
| dbg_req_o | output | 1 | Debug-port request valid |
| dbg_kind_o | output | 3 | Request kind: 1 set watchpoint, 2 set breakpoint, 3 read, 4 write, 5 resume |
| dbg_addr_o | output | 32 | Request address |
| dbg_data_o | output | 32 | Request write data |
| dbg_ack_i | input | 1 | Request accepted (read data valid for a read) |
| dbg_rdata_i | input | 32 | Read data returned with the acknowledge |
| msg_valid_i | input | 1 | Target debug message valid |
| msg_data_i | input | 32 | Target debug message word |
| trace_raddr_i | input | 3 | Trace array read location |
| trace_rdata_o | output | 32 | Trace word at `trace_raddr_i` |
| trace_count_o | output | 4 | Number of messages stored |
| trace_ovf_o | output | 1 | Message dropped because the trace array was full |
| done_o | output | 1 | Campaign finished |

## Verification
Trace logging runs independently of the command engine, so a target message can arrive in the same cycle that the read half of a read-modify-write is acknowledged. The bench provokes this in every iteration of a sweep over all 32 single-bit masks by sending a message exactly at the read acknowledge. It then judges both effects: the write-back must carry the returned word with only the masked bit flipped, and the trace must hold exactly that message as its single entry.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_NOP    = 4'd0,
    OP_SETWP  = 4'd1,
    OP_SETBP  = 4'd2,
    OP_DELAY  = 4'd3,
    OP_WAITEV = 4'd4,
    OP_WRITE  = 4'd5,
    OP_RMW    = 4'd6,
    OP_RESUME = 4'd7,
    OP_END    = 4'd8
  } op_e;

  typedef enum logic [2:0] {
    K_NONE   = 3'd0,
    K_SETWP  = 3'd1,
    K_SETBP  = 3'd2,
    K_READ   = 3'd3,
    K_WRITE  = 3'd4,
    K_RESUME = 3'd5
  } kind_e;

  typedef enum logic [2:0] {
    S_IDLE, S_EXEC, S_REQ, S_DLY, S_WAIT, S_DONE
  } state_e;
endpackage

// File: rtl/fcs_script_mem.sv
module fcs_script_mem #(
  parameter int DEPTH  = 16,
  parameter int WORD_W = 68,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [WORD_W-1:0] rd_data_o
);
  logic [WORD_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_addr_i] <= wr_data_i;
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/fcs_trace_log.sv
module fcs_trace_log #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              msg_valid_i,
  input  logic [DATA_W-1:0] msg_data_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [CW-1:0]     count_o,
  output logic              overflow_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [CW-1:0]     count_q;
  logic              ovf_q;
  logic              full;

  assign full = (count_q == CW'(DEPTH));

  always_ff @(posedge clk_i) begin
    if (msg_valid_i && !full) mem_q[count_q[AW-1:0]] <= msg_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      ovf_q   <= 1'b0;
    end else if (msg_valid_i) begin
      if (full) ovf_q <= 1'b1;
      else      count_q <= count_q + 1'b1;
    end
  end

  assign rd_data_o  = mem_q[rd_addr_i];
  assign count_o    = count_q;
  assign overflow_o = ovf_q;

  a_r9_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_i && count_o != CW'(DEPTH)) |=> count_o == $past(count_o) + 1'b1);
  a_r10_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o);
  a_r10_ovf_only_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overflow_o) |-> count_o == CW'(DEPTH));
endmodule

// File: rtl/fcs_ctrl.sv
module fcs_ctrl
  import fcs_pkg::*;
#(
  parameter int SCRIPT_DEPTH = 16,
  parameter int ADDR_W       = 32,
  parameter int DATA_W       = 32,
  localparam int SAW         = $clog2(SCRIPT_DEPTH),
  localparam int CMD_W       = OP_W + ADDR_W + DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CMD_W-1:0]  cmd_i,
  output logic [SAW-1:0]    pc_o,
  input  logic              wp_hit_i,
  input  logic              ext_trig_i,
  output logic              dbg_req_o,
  output logic [2:0]        dbg_kind_o,
  output logic [ADDR_W-1:0] dbg_addr_o,
  output logic [DATA_W-1:0] dbg_data_o,
  input  logic              dbg_ack_i,
  input  logic [DATA_W-1:0] dbg_rdata_i,
  output logic              done_o
);
  state_e            state_q, state_d;
  logic [SAW-1:0]    pc_q, pc_d;
  kind_e             kind_q, kind_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] data_q, data_d, mask_q, mask_d, cnt_q, cnt_d;
  logic              rmw_q, rmw_d, adv;

  op_e               op;
  logic [ADDR_W-1:0] c_addr;
  logic [DATA_W-1:0] c_opnd;

  assign op     = op_e'(cmd_i[CMD_W-1 -: OP_W]);
  assign c_addr = cmd_i[DATA_W +: ADDR_W];
  assign c_opnd = cmd_i[DATA_W-1:0];

  always_comb begin
    state_d = state_q; pc_d = pc_q; kind_d = kind_q; addr_d = addr_q;
    data_d = data_q; mask_d = mask_q; cnt_d = cnt_q; rmw_d = rmw_q;
    adv = 1'b0;
    unique case (state_q)
      S_IDLE, S_DONE: if (start_i) begin
        state_d = S_EXEC;
        pc_d    = '0;
      end
      S_EXEC: begin
        addr_d = c_addr;
        data_d = '0;
        case (op)
          OP_SETWP:  begin kind_d = K_SETWP;  state_d = S_REQ; end
          OP_SETBP:  begin kind_d = K_SETBP;  state_d = S_REQ; end
          OP_RESUME: begin kind_d = K_RESUME; state_d = S_REQ; end
          OP_WRITE:  begin kind_d = K_WRITE;  data_d = c_opnd; state_d = S_REQ; end
          OP_RMW: begin
            kind_d  = K_READ;
            mask_d  = c_opnd;
            rmw_d   = 1'b1;
            state_d = S_REQ;
          end
          OP_DELAY: begin
            if (c_opnd == '0) adv = 1'b1;
            else begin
              cnt_d   = c_opnd;
              state_d = S_DLY;
            end
          end
          OP_WAITEV: state_d = S_WAIT;
          OP_END:    state_d = S_DONE;
          default:   adv = 1'b1;
        endcase
      end
      S_REQ: if (dbg_ack_i) begin
        if (rmw_q) begin
          // read returned: turn straight into the write-back
          rmw_d  = 1'b0;
          kind_d = K_WRITE;
          data_d = dbg_rdata_i ^ mask_q;
        end else begin
          adv = 1'b1;
        end
      end
      S_DLY: begin
        if (cnt_q == DATA_W'(1)) adv = 1'b1;
        else cnt_d = cnt_q - 1'b1;
      end
      S_WAIT: if (wp_hit_i || ext_trig_i) adv = 1'b1;
      default: state_d = S_IDLE;
    endcase
    if (adv) begin
      if (pc_q == SAW'(SCRIPT_DEPTH - 1)) state_d = S_DONE;
      else begin
        pc_d    = pc_q + 1'b1;
        state_d = S_EXEC;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      pc_q    <= '0;
      kind_q  <= K_NONE;
      addr_q  <= '0;
      data_q  <= '0;
      mask_q  <= '0;
      cnt_q   <= '0;
      rmw_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      pc_q    <= pc_d;
      kind_q  <= kind_d;
      addr_q  <= addr_d;
      data_q  <= data_d;
      mask_q  <= mask_d;
      cnt_q   <= cnt_d;
      rmw_q   <= rmw_d;
    end
  end

  assign pc_o       = pc_q;
  assign dbg_req_o  = (state_q == S_REQ);
  assign dbg_kind_o = kind_q;
  assign dbg_addr_o = addr_q;
  assign dbg_data_o = data_q;
  assign done_o     = (state_q == S_DONE);

  a_r2_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_req_o && !dbg_ack_i) |=> dbg_req_o && $stable(dbg_kind_o)
                                  && $stable(dbg_addr_o) && $stable(dbg_data_o));
  a_r3_delay_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_DLY) |=> !dbg_req_o);
  a_r4_wait_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_WAIT && !wp_hit_i && !ext_trig_i) |=> !dbg_req_o);
  a_r6_rmw_writeback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_req_o && dbg_ack_i && dbg_kind_o == K_READ)
      |=> dbg_req_o && dbg_kind_o == K_WRITE && $stable(dbg_addr_o));
  a_r8_done_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o && !dbg_req_o);
endmodule

// File: rtl/fault_campaign_seq.sv
module fault_campaign_seq
  import fcs_pkg::*;
#(
  parameter int SCRIPT_DEPTH = 16,
  parameter int TRACE_DEPTH  = 8,
  parameter int ADDR_W       = 32,
  parameter int DATA_W       = 32,
  localparam int SAW         = $clog2(SCRIPT_DEPTH),
  localparam int TAW         = $clog2(TRACE_DEPTH),
  localparam int TCW         = $clog2(TRACE_DEPTH + 1),
  localparam int CMD_W       = OP_W + ADDR_W + DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              script_we_i,
  input  logic [SAW-1:0]    script_waddr_i,
  input  logic [CMD_W-1:0]  script_wdata_i,
  input  logic              wp_hit_i,
  input  logic              ext_trig_i,
  output logic              dbg_req_o,
  output logic [2:0]        dbg_kind_o,
  output logic [ADDR_W-1:0] dbg_addr_o,
  output logic [DATA_W-1:0] dbg_data_o,
  input  logic              dbg_ack_i,
  input  logic [DATA_W-1:0] dbg_rdata_i,
  input  logic              msg_valid_i,
  input  logic [DATA_W-1:0] msg_data_i,
  input  logic [TAW-1:0]    trace_raddr_i,
  output logic [DATA_W-1:0] trace_rdata_o,
  output logic [TCW-1:0]    trace_count_o,
  output logic              trace_ovf_o,
  output logic              done_o
);
  logic [SAW-1:0]   pc;
  logic [CMD_W-1:0] cmd;

  fcs_script_mem #(.DEPTH(SCRIPT_DEPTH), .WORD_W(CMD_W)) u_script (
    .clk_i, .wr_en_i(script_we_i), .wr_addr_i(script_waddr_i),
    .wr_data_i(script_wdata_i), .rd_addr_i(pc), .rd_data_o(cmd)
  );

  fcs_ctrl #(.SCRIPT_DEPTH(SCRIPT_DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk_i, .rst_ni, .start_i, .cmd_i(cmd), .pc_o(pc),
    .wp_hit_i, .ext_trig_i, .dbg_req_o, .dbg_kind_o, .dbg_addr_o,
    .dbg_data_o, .dbg_ack_i, .dbg_rdata_i, .done_o
  );

  fcs_trace_log #(.DEPTH(TRACE_DEPTH), .DATA_W(DATA_W)) u_trace (
    .clk_i, .rst_ni, .msg_valid_i, .msg_data_i,
    .rd_addr_i(trace_raddr_i), .rd_data_o(trace_rdata_o),
    .count_o(trace_count_o), .overflow_o(trace_ovf_o)
  );
endmodule

// File: tb/fault_campaign_seq_test.sv
module fault_campaign_seq_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        script_we_i = 1'b0;
  logic [3:0]  script_waddr_i = '0;
  logic [67:0] script_wdata_i = '0;
  logic        wp_hit_i = 1'b0, ext_trig_i = 1'b0;
  logic        dbg_req_o;
  logic [2:0]  dbg_kind_o;
  logic [31:0] dbg_addr_o, dbg_data_o;
  logic        dbg_ack_i = 1'b0;
  logic [31:0] dbg_rdata_i = '0;
  logic        msg_valid_i = 1'b0;
  logic [31:0] msg_data_i = '0;
  logic [2:0]  trace_raddr_i = '0;
  logic [31:0] trace_rdata_o;
  logic [3:0]  trace_count_o;
  logic        trace_ovf_o, done_o;

  fault_campaign_seq uut (.*);

  always #4 clk_i = ~clk_i;

  int errors = 0, checks = 0, cyc = 0, nreq = 0, nmsg = 0;
  int rs[16], rack[16];
  logic [2:0]  rk[16];
  logic [31:0] ra[16], rdd[16], em[32];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic put(input int idx, input logic [3:0] op, input logic [31:0] a,
                     input logic [31:0] d);
    @(negedge clk_i);
    script_we_i = 1'b1; script_waddr_i = 4'(idx); script_wdata_i = {op, a, d};
    @(negedge clk_i);
    script_we_i = 1'b0;
  endtask

  task automatic clear_script();
    for (int i = 0; i < 16; i++) put(i, 4'd0, '0, '0);
  endtask

  task automatic send(input logic [31:0] d);
    if (nmsg < 32) em[nmsg] = d;
    nmsg++;
    msg_valid_i = 1'b1; msg_data_i = d;
  endtask

  task automatic run(input int lat, input int ev_at, input bit ev_wp, input int msg_every,
                     input int msg_until, input bit msg_on_read, input logic [31:0] rd_val,
                     input int max_cyc);
    int wcnt = 0;
    nreq = 0; nmsg = 0; cyc = 0;
    dbg_rdata_i = rd_val;
    @(negedge clk_i); start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
    while (!done_o && cyc < max_cyc) begin
      @(negedge clk_i);
      cyc++;
      dbg_ack_i = 1'b0; msg_valid_i = 1'b0; wp_hit_i = 1'b0; ext_trig_i = 1'b0;
      if (cyc == ev_at) begin
        if (ev_wp) wp_hit_i = 1'b1; else ext_trig_i = 1'b1;
      end
      if (msg_every > 0 && cyc <= msg_until && cyc % msg_every == 0)
        send(32'hC0DE0000 + 32'(cyc));
      if (dbg_req_o && nreq < 16) begin
        if (wcnt == 0) begin
          rs[nreq] = cyc; rk[nreq] = dbg_kind_o; ra[nreq] = dbg_addr_o; rdd[nreq] = dbg_data_o;
        end
        if (wcnt == lat) begin
          dbg_ack_i = 1'b1; rack[nreq] = cyc;
          if (msg_on_read && dbg_kind_o == 3'd3) send(32'h5EED0000 + 32'(cyc));
          nreq++; wcnt = 0;
        end else wcnt++;
      end
    end
    @(negedge clk_i);
    dbg_ack_i = 1'b0; msg_valid_i = 1'b0; wp_hit_i = 1'b0; ext_trig_i = 1'b0;
    chk(done_o == 1'b1, "R8", "done after campaign", 64'(done_o), 64'd1);
  endtask

  task automatic chk_trace(input string req);
    int exp_cnt = (nmsg > 8) ? 8 : nmsg;
    chk(trace_count_o == 4'(exp_cnt), req, "trace count", 64'(trace_count_o), 64'(exp_cnt));
    chk(trace_ovf_o == (nmsg > 8), "R10", "overflow flag", 64'(trace_ovf_o), 64'(nmsg > 8));
    for (int i = 0; i < exp_cnt; i++) begin
      trace_raddr_i = 3'(i);
      #1;
      chk(trace_rdata_o == em[i], req, "trace entry", 64'(trace_rdata_o), 64'(em[i]));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    chk(done_o == 0 && dbg_req_o == 0, "R1", "done/req after reset", {62'd0, done_o, dbg_req_o}, 64'd0);
    chk(trace_count_o == 0 && trace_ovf_o == 0, "R1", "trace after reset",
        {59'd0, trace_ovf_o, trace_count_o}, 64'd0);
    clear_script();
    put(0, 4'd1, 32'h0000_4000, '0);
    put(1, 4'd8, '0, '0);
    repeat (5) @(negedge clk_i);
    chk(dbg_req_o == 0 && done_o == 0, "R1", "idle without start", 64'(dbg_req_o), 64'd0);

    // R2 R4 R5 R9: set watchpoint, wait, predetermined write; both trigger sources, latencies
    for (int v = 0; v < 6; v++) begin
      do_reset();
      clear_script();
      put(0, 4'd1, 32'h0000_4000 + 32'(v), '0);
      put(1, 4'd4, '0, '0);
      put(2, 4'd5, 32'h0000_8000 + 32'(v), 32'hDEAD_0000 + 32'(v));
      put(3, 4'd8, '0, '0);
      run(v % 3, 20 + v, v[0], 2, 10, 1'b0, '0, 200);
      chk(nreq == 2, "R8", "requests before END", 64'(nreq), 64'd2);
      chk(rk[0] == 3'd1 && ra[0] == 32'h0000_4000 + 32'(v), "R2", "setwp kind/addr",
          {29'd0, rk[0], ra[0]}, {29'd0, 3'd1, 32'h0000_4000 + 32'(v)});
      chk(rack[0] - rs[0] == v % 3, "R2", "held until ack", 64'(rack[0] - rs[0]), 64'(v % 3));
      chk(rs[1] == 22 + v, "R4", "request after trigger", 64'(rs[1]), 64'(22 + v));
      chk(rk[1] == 3'd4 && ra[1] == 32'h0000_8000 + 32'(v) && rdd[1] == 32'hDEAD_0000 + 32'(v),
          "R5", "write kind/addr/data", {rk[1], ra[1], rdd[1]},
          {3'd4, 32'h0000_8000 + 32'(v), 32'hDEAD_0000 + 32'(v)});
      chk_trace("R9");
      repeat (4) @(negedge clk_i);
      chk(done_o == 1 && dbg_req_o == 0, "R8", "stays done and quiet", 64'(dbg_req_o), 64'd0);
    end

    // R3: delay sweep
    for (int n = 0; n < 6; n++) begin
      do_reset();
      clear_script();
      put(0, 4'd1, 32'h10, '0);
      put(1, 4'd3, '0, 32'(n));
      put(2, 4'd5, 32'h20, 32'h77);
      put(3, 4'd8, '0, '0);
      run(1, 0, 1'b0, 0, 0, 1'b0, '0, 200);
      chk(rs[1] == rack[0] + n + 3, "R3", "delay length", 64'(rs[1] - rack[0]), 64'(n + 3));
    end

    // R6 R7 R9 (same-cycle message at read ack): single-bit mask sweep on a register target
    for (int k = 0; k < 32; k++) begin
      logic [31:0] rv, mask, a;
      rv = 32'h3C3C_0000 + 32'(k * 7);
      mask = 32'(1) << k;
      a = 32'h0000_0100 + 32'(k);
      do_reset();
      clear_script();
      put(0, 4'd2, 32'hB000, '0);
      put(1, 4'd4, '0, '0);
      put(2, 4'd6, a, mask);
      put(3, 4'd7, '0, '0);
      put(4, 4'd8, '0, '0);
      run(k % 3, 12, k[0], 0, 0, 1'b1, rv, 200);
      chk(rk[0] == 3'd2, "R2", "setbp kind", 64'(rk[0]), 64'd2);
      chk(rk[1] == 3'd3 && ra[1] == a && rs[1] == 14, "R6", "read kind/addr/time",
          {rk[1], ra[1], 16'(rs[1])}, {3'd3, a, 16'd14});
      chk(rk[2] == 3'd4 && ra[2] == a && rdd[2] == (rv ^ mask) && rs[2] == rack[1] + 1,
          "R6", "write-back", {rk[2], rdd[2]}, {3'd4, rv ^ mask});
      chk($countones(rdd[2] ^ rv) == 1, "R6", "single bit flipped",
          64'($countones(rdd[2] ^ rv)), 64'd1);
      chk(rk[3] == 3'd5 && nreq == 4, "R7", "resume after write", 64'(rk[3]), 64'd5);
      chk_trace("R9");
    end

    // R8: last script location ends the campaign without END
    do_reset();
    clear_script();
    put(0, 4'd1, 32'h1, '0);
    put(7, 4'd15, 32'h2, '0);
    put(15, 4'd5, 32'h3, 32'h4);
    run(0, 0, 1'b0, 0, 0, 1'b0, '0, 200);
    chk(nreq == 2 && rk[1] == 3'd4 && ra[1] == 32'h3, "R8", "last location executed then done",
        64'(nreq), 64'd2);

    // R10: overflow
    do_reset();
    clear_script();
    put(0, 4'd4, '0, '0);
    put(1, 4'd8, '0, '0);
    run(0, 20, 1'b1, 1, 12, 1'b0, '0, 200);
    chk(nmsg == 12, "R10", "messages sent", 64'(nmsg), 64'd12);
    chk_trace("R10");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule